// File: doc/BRIEF.md
# Leveled Interrupt Priority Controller

This block gathers interrupt requests from many sources. The sources are grouped into numbered priority levels. Each level keeps a bitmap with one bit per source. A summary word holds one bit for every level whose bitmap is not empty. Requests arrive on three command ports: set one bit, remove one bit, or wipe everything. Software-raised levels come in on a separate request word.

Each cycle the block works out a winning priority from the registered state. A software level is renumbered to a 1-based priority. An external level keeps its own index. The winner is compared with the processor's current priority level. When the winner is higher, and the fetch address is word aligned, the block raises an interrupt request. It also holds the winning priority and the mask of contributing levels.

A separate commit strobe later moves the held pair into the visible status and identifier registers. An illegal command, or a commit with nothing held, produces a one-cycle error pulse.

Top module: `lvl_irq_ctrl`

## Requirements
- R1: A set command with level below NL (32) and source below NS (64) sets that source's bit in that level's bitmap. One cycle later, bit `level` of `lvl_status` is 1.
- R2: A remove command clears one source bit. The level's `lvl_status` bit drops only when that level's whole bitmap is zero. When a set and a remove hit the same bit in the same cycle, the bit ends up set.
- R3: `wipe_all` zeroes every bitmap and `lvl_status` in one cycle. It overrides any set or remove in the same cycle.
- R4: `irq_pending` is 1 exactly when `lvl_status` is non-zero and `pc_lo` equals 2'b00.
- R5: For each bit i of `sw_req` with 1 ≤ i ≤ 15, the candidate priority becomes i − 1 + 1 and bit i of the candidate mask is set. Other `sw_req` bits are ignored.
- R6: For each bit i of `lvl_status` with 16 ≤ i ≤ 31, the candidate priority becomes i and bit i of the mask is set. External levels are evaluated after software levels, so the highest set level wins.
- R7: `intr_req` is 1 exactly when `irq_pending` is 1, the candidate is non-zero, and the candidate is strictly greater than `cur_ipl` (unsigned).
- R8: In a cycle with `intr_req` high, the candidate and mask are held and `held_valid` becomes 1. A `commit` while `held_valid` is 1 copies the held mask to `isr_out` and the held priority to `intid_out`. It clears `held_valid` unless `intr_req` is high in the same cycle. In that case the previously held values are copied and the new ones are held.
- R9: A set or remove whose level is ≥ NL or whose source is ≥ NS changes no state. It produces `err_pulse` high for exactly the next cycle.
- R10: A `commit` while `held_valid` is 0 leaves `isr_out` and `intid_out` unchanged and produces an `err_pulse` on the next cycle.
- R11: After reset every bitmap, `lvl_status`, `held_valid`, `isr_out`, `intid_out` and `err_pulse` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| set_en | input | 1 | Set-bit command strobe |
| set_lvl | input | 6 | Level for the set command |
| set_src | input | 7 | Source index for the set command |
| rem_en | input | 1 | Remove-bit command strobe |
| rem_lvl | input | 6 | Level for the remove command |
| rem_src | input | 7 | Source index for the remove command |
| wipe_all | input | 1 | Clear every bitmap and the summary |
| sw_req | input | 32 | Software-raised level requests |
| cur_ipl | input | 6 | Current processor priority level |
| pc_lo | input | 2 | Two lowest bits of the fetch address |
| commit | input | 1 | Transfer held priority and mask to the status registers |
| lvl_status | output | 32 | Non-empty level summary word |
| irq_pending | output | 1 | Summary non-zero and address aligned |
| intr_req | output | 1 | Interrupt request to the core |
| held_valid | output | 1 | A priority/mask pair is held |
| isr_out | output | 32 | Committed level mask |
| intid_out | output | 6 | Committed priority |
| err_pulse | output | 1 | One-cycle error indication |

## Verification
Three pairs of functions can fall in the same cycle. A set and a remove can target the same level and source. A wipe can coincide with either command. A commit can meet a fresh request-take.

The bench drives each pair directly in a fixed cycle. It also draws sources from a pool of four per level, so random traffic produces many of these coincidences. A reference model in the bench decides each outcome. The set wins over the remove, and the wipe wins over both. On the commit/take overlap, the old held pair is committed and the new one is held. The model's result is compared with the summary word, the status registers and the error pulse on the following cycle.

// File: rtl/lvl_irq_pkg.sv
package lvl_irq_pkg;
  // width that can carry values 0..n, so out-of-range requests are expressible
  function automatic int unsigned wide_w(int unsigned n);
    return $clog2(n) + 1;
  endfunction

  // mask of levels inside an inclusive range
  function automatic logic [63:0] range_mask(int unsigned lo, int unsigned hi);
    logic [63:0] m;
    m = '0;
    for (int i = 0; i < 64; i++)
      if (i >= lo && i <= hi) m[i] = 1'b1;
    return m;
  endfunction
endpackage

// File: rtl/lvl_irq_store.sv
module lvl_irq_store
  import lvl_irq_pkg::*;
#(
  parameter int NL = 32,
  parameter int NS = 64,
  localparam int LW  = wide_w(NL),
  localparam int SW  = wide_w(NS),
  localparam int LIW = $clog2(NL),
  localparam int SIW = $clog2(NS)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          set_en,
  input  logic [LW-1:0] set_lvl,
  input  logic [SW-1:0] set_src,
  input  logic          rem_en,
  input  logic [LW-1:0] rem_lvl,
  input  logic [SW-1:0] rem_src,
  input  logic          wipe_all,
  output logic [NL-1:0] status_q,
  output logic          bad_cmd
);
  logic set_ok, rem_ok;
  logic [LIW-1:0] set_l, rem_l;
  logic [SIW-1:0] set_i, rem_i;
  logic [NL-1:0]  nz_next;

  assign set_ok  = set_en && (int'(set_lvl) < NL) && (int'(set_src) < NS);
  assign rem_ok  = rem_en && (int'(rem_lvl) < NL) && (int'(rem_src) < NS);
  assign bad_cmd = (set_en && !set_ok) || (rem_en && !rem_ok);
  assign set_l   = set_lvl[LIW-1:0];
  assign rem_l   = rem_lvl[LIW-1:0];
  assign set_i   = set_src[SIW-1:0];
  assign rem_i   = rem_src[SIW-1:0];

  // one bitmap row per level; set is applied after remove so it wins
  for (genvar g = 0; g < NL; g++) begin : g_row
    logic [NS-1:0] row_q, row_d;

    always_comb begin
      row_d = row_q;
      if (rem_ok && rem_l == LIW'(g)) row_d[rem_i] = 1'b0;
      if (set_ok && set_l == LIW'(g)) row_d[set_i] = 1'b1;
    end

    assign nz_next[g] = |row_d;

    always_ff @(posedge clk) begin
      if (rst || wipe_all) row_q <= '0;
      else                 row_q <= row_d;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || wipe_all) status_q <= '0;
    else                 status_q <= nz_next;
  end
endmodule

// File: rtl/lvl_irq_eval.sv
module lvl_irq_eval
  import lvl_irq_pkg::*;
#(
  parameter int NL     = 32,
  parameter int SW_LO  = 1,
  parameter int SW_HI  = 15,
  parameter int EXT_LO = 16,
  parameter int EXT_HI = 31,
  localparam int LW = wide_w(NL)
) (
  input  logic [NL-1:0] status_q,
  input  logic [NL-1:0] sw_req,
  input  logic [LW-1:0] cur_ipl,
  input  logic [1:0]    pc_lo,
  output logic          pending,
  output logic          take,
  output logic [LW-1:0] cand_ipl,
  output logic [NL-1:0] cand_sum
);
  // software levels first, then external ones; the last hit overwrites
  always_comb begin
    cand_ipl = '0;
    cand_sum = '0;
    for (int i = 0; i < NL; i++) begin
      if (i >= SW_LO && i <= SW_HI && sw_req[i]) begin
        cand_ipl    = LW'(i - SW_LO + 1);
        cand_sum[i] = 1'b1;
      end
    end
    for (int i = 0; i < NL; i++) begin
      if (i >= EXT_LO && i <= EXT_HI && status_q[i]) begin
        cand_ipl    = LW'(i);
        cand_sum[i] = 1'b1;
      end
    end
  end

  assign pending = (|status_q) && (pc_lo == 2'b00);
  assign take    = pending && (cand_ipl != '0) && (cand_ipl > cur_ipl);
endmodule

// File: rtl/lvl_irq_stage.sv
module lvl_irq_stage
  import lvl_irq_pkg::*;
#(
  parameter int NL = 32,
  localparam int LW = wide_w(NL)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          take,
  input  logic [LW-1:0] cand_ipl,
  input  logic [NL-1:0] cand_sum,
  input  logic          commit,
  input  logic          bad_cmd,
  output logic          held_valid,
  output logic [NL-1:0] isr_out,
  output logic [LW-1:0] intid_out,
  output logic          err_pulse
);
  logic [LW-1:0] held_ipl;
  logic [NL-1:0] held_sum;
  logic          do_commit;

  assign do_commit = commit && held_valid;

  always_ff @(posedge clk) begin
    if (rst) begin
      held_valid <= 1'b0;
      held_ipl   <= '0;
      held_sum   <= '0;
      isr_out    <= '0;
      intid_out  <= '0;
      err_pulse  <= 1'b0;
    end else begin
      err_pulse <= bad_cmd || (commit && !held_valid);
      if (do_commit) begin
        isr_out   <= held_sum;
        intid_out <= held_ipl;
      end
      if (take) begin
        held_ipl   <= cand_ipl;
        held_sum   <= cand_sum;
        held_valid <= 1'b1;
      end else if (do_commit) begin
        held_valid <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/lvl_irq_ctrl.sv
module lvl_irq_ctrl
  import lvl_irq_pkg::*;
#(
  parameter int NL     = 32,
  parameter int NS     = 64,
  parameter int SW_LO  = 1,
  parameter int SW_HI  = 15,
  parameter int EXT_LO = 16,
  parameter int EXT_HI = 31,
  localparam int LW = wide_w(NL),
  localparam int SW = wide_w(NS)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          set_en,
  input  logic [LW-1:0] set_lvl,
  input  logic [SW-1:0] set_src,
  input  logic          rem_en,
  input  logic [LW-1:0] rem_lvl,
  input  logic [SW-1:0] rem_src,
  input  logic          wipe_all,
  input  logic [NL-1:0] sw_req,
  input  logic [LW-1:0] cur_ipl,
  input  logic [1:0]    pc_lo,
  input  logic          commit,
  output logic [NL-1:0] lvl_status,
  output logic          irq_pending,
  output logic          intr_req,
  output logic          held_valid,
  output logic [NL-1:0] isr_out,
  output logic [LW-1:0] intid_out,
  output logic          err_pulse
);
  logic          bad_cmd;
  logic [LW-1:0] cand_ipl;
  logic [NL-1:0] cand_sum;

  lvl_irq_store #(.NL(NL), .NS(NS)) u_store (
    .clk(clk), .rst(rst),
    .set_en(set_en), .set_lvl(set_lvl), .set_src(set_src),
    .rem_en(rem_en), .rem_lvl(rem_lvl), .rem_src(rem_src),
    .wipe_all(wipe_all), .status_q(lvl_status), .bad_cmd(bad_cmd)
  );

  lvl_irq_eval #(.NL(NL), .SW_LO(SW_LO), .SW_HI(SW_HI),
                 .EXT_LO(EXT_LO), .EXT_HI(EXT_HI)) u_eval (
    .status_q(lvl_status), .sw_req(sw_req), .cur_ipl(cur_ipl), .pc_lo(pc_lo),
    .pending(irq_pending), .take(intr_req), .cand_ipl(cand_ipl), .cand_sum(cand_sum)
  );

  lvl_irq_stage #(.NL(NL)) u_stage (
    .clk(clk), .rst(rst), .take(intr_req), .cand_ipl(cand_ipl), .cand_sum(cand_sum),
    .commit(commit), .bad_cmd(bad_cmd), .held_valid(held_valid),
    .isr_out(isr_out), .intid_out(intid_out), .err_pulse(err_pulse)
  );
endmodule

// File: rtl/lvl_irq_ctrl_chk.sv
module lvl_irq_ctrl_chk
  import lvl_irq_pkg::*;
#(
  parameter int NL = 32,
  parameter int NS = 64,
  localparam int LW  = wide_w(NL),
  localparam int SW  = wide_w(NS),
  localparam int LIW = $clog2(NL)
) (
  input logic          clk,
  input logic          rst,
  input logic          set_en,
  input logic [LW-1:0] set_lvl,
  input logic [SW-1:0] set_src,
  input logic          rem_en,
  input logic          wipe_all,
  input logic [LW-1:0] cur_ipl,
  input logic [1:0]    pc_lo,
  input logic          commit,
  input logic [NL-1:0] lvl_status,
  input logic          intr_req,
  input logic          held_valid,
  input logic [NL-1:0] isr_out,
  input logic [LW-1:0] intid_out,
  input logic          err_pulse
);
  logic set_good, set_bad;
  assign set_good = set_en && (int'(set_lvl) < NL) && (int'(set_src) < NS);
  assign set_bad  = set_en && !set_good;

  assert_set_marks_R1: assert property (@(posedge clk) disable iff (rst)
    (set_good && !wipe_all) |=> lvl_status[$past(set_lvl[LIW-1:0])]);

  assert_wipe_empties_R3: assert property (@(posedge clk) disable iff (rst)
    wipe_all |=> (lvl_status == '0));

  assert_misaligned_blocks_R4: assert property (@(posedge clk) disable iff (rst)
    (pc_lo != 2'b00) |-> !intr_req);

  assert_ipl_ceiling_R7: assert property (@(posedge clk) disable iff (rst)
    (int'(cur_ipl) >= NL) |-> !intr_req);

  assert_take_holds_R8: assert property (@(posedge clk) disable iff (rst)
    intr_req |=> held_valid);

  assert_commit_drains_R8: assert property (@(posedge clk) disable iff (rst)
    (commit && held_valid && !intr_req) |=> !held_valid);

  assert_bad_cmd_R9: assert property (@(posedge clk) disable iff (rst)
    (set_bad && !rem_en && !wipe_all) |=> (err_pulse && $stable(lvl_status)));

  assert_empty_commit_R10: assert property (@(posedge clk) disable iff (rst)
    (commit && !held_valid) |=> (err_pulse && $stable(isr_out) && $stable(intid_out)));
endmodule

bind lvl_irq_ctrl lvl_irq_ctrl_chk #(.NL(NL), .NS(NS)) u_chk (
  .clk(clk), .rst(rst), .set_en(set_en), .set_lvl(set_lvl), .set_src(set_src),
  .rem_en(rem_en), .wipe_all(wipe_all), .cur_ipl(cur_ipl), .pc_lo(pc_lo),
  .commit(commit), .lvl_status(lvl_status), .intr_req(intr_req),
  .held_valid(held_valid), .isr_out(isr_out), .intid_out(intid_out),
  .err_pulse(err_pulse)
);

// File: tb/lvl_irq_ctrl_test.sv
`timescale 1ns/100ps
module lvl_irq_ctrl_test;
  logic        clk = 1'b0;
  logic        rst;
  logic        set_en, rem_en, wipe_all, commit;
  logic [5:0]  set_lvl, rem_lvl, cur_ipl;
  logic [6:0]  set_src, rem_src;
  logic [31:0] sw_req;
  logic [1:0]  pc_lo;
  logic [31:0] lvl_status, isr_out;
  logic        irq_pending, intr_req, held_valid, err_pulse;
  logic [5:0]  intid_out;

  int n_checks = 0;
  int n_errs   = 0;

  // reference model state
  logic [63:0] m_rows [32];
  logic [31:0] m_stat, m_hsum, m_isr;
  logic [5:0]  m_hipl, m_intid;
  logic        m_valid, m_err;

  always #2.5 clk = ~clk;

  lvl_irq_ctrl uut (
    .clk(clk), .rst(rst), .set_en(set_en), .set_lvl(set_lvl), .set_src(set_src),
    .rem_en(rem_en), .rem_lvl(rem_lvl), .rem_src(rem_src), .wipe_all(wipe_all),
    .sw_req(sw_req), .cur_ipl(cur_ipl), .pc_lo(pc_lo), .commit(commit),
    .lvl_status(lvl_status), .irq_pending(irq_pending), .intr_req(intr_req),
    .held_valid(held_valid), .isr_out(isr_out), .intid_out(intid_out),
    .err_pulse(err_pulse)
  );

  task automatic chk(input bit ok, input string tag, input logic [63:0] act,
                     input logic [63:0] exp);
    n_checks++;
    if (!ok) begin
      n_errs++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // candidate per R5/R6, pending per R4, take per R7
  task automatic calc(output logic [5:0] ipl, output logic [31:0] sum,
                      output bit pend, output bit tk);
    ipl = '0; sum = '0;
    for (int i = 1; i <= 15; i++)
      if (sw_req[i]) begin ipl = 6'(i - 1 + 1); sum[i] = 1'b1; end
    for (int i = 16; i <= 31; i++)
      if (m_stat[i]) begin ipl = 6'(i); sum[i] = 1'b1; end
    pend = (m_stat != 0) && (pc_lo == 2'b00);
    tk   = pend && (ipl != 0) && (ipl > cur_ipl);
  endtask

  task automatic model_reset();
    for (int l = 0; l < 32; l++) m_rows[l] = '0;
    m_stat = '0; m_hsum = '0; m_isr = '0; m_hipl = '0; m_intid = '0;
    m_valid = 1'b0; m_err = 1'b0;
  endtask

  task automatic model_edge();
    logic [5:0] e_ipl; logic [31:0] e_sum; bit e_pend, e_take, pok, cok, cv;
    calc(e_ipl, e_sum, e_pend, e_take);
    pok = set_en && set_lvl < 32 && set_src < 64;
    cok = rem_en && rem_lvl < 32 && rem_src < 64;
    cv  = commit && m_valid;
    m_err = (set_en && !pok) || (rem_en && !cok) || (commit && !m_valid);
    if (cv) begin m_isr = m_hsum; m_intid = m_hipl; end
    if (e_take) begin m_hipl = e_ipl; m_hsum = e_sum; m_valid = 1'b1; end
    else if (cv) m_valid = 1'b0;
    if (wipe_all) begin
      for (int l = 0; l < 32; l++) m_rows[l] = '0;
    end else begin
      if (cok) m_rows[rem_lvl[4:0]][rem_src[5:0]] = 1'b0;
      if (pok) m_rows[set_lvl[4:0]][set_src[5:0]] = 1'b1;
    end
    for (int l = 0; l < 32; l++) m_stat[l] = |m_rows[l];
  endtask

  task automatic check_comb();
    logic [5:0] e_ipl; logic [31:0] e_sum; bit e_pend, e_take;
    calc(e_ipl, e_sum, e_pend, e_take);
    chk(irq_pending == e_pend, "R4 irq_pending", 64'(irq_pending), 64'(e_pend));
    chk(intr_req == e_take, "R5 R6 R7 intr_req", 64'(intr_req), 64'(e_take));
  endtask

  task automatic check_regs(input string tag);
    chk(lvl_status == m_stat, {tag, " R1 R2 R3 R9 lvl_status"}, 64'(lvl_status), 64'(m_stat));
    chk(held_valid == m_valid, {tag, " R8 held_valid"}, 64'(held_valid), 64'(m_valid));
    chk(isr_out == m_isr, {tag, " R8 R10 isr_out"}, 64'(isr_out), 64'(m_isr));
    chk(intid_out == m_intid, {tag, " R8 R10 intid_out"}, 64'(intid_out), 64'(m_intid));
    chk(err_pulse == m_err, {tag, " R9 R10 err_pulse"}, 64'(err_pulse), 64'(m_err));
  endtask

  // inputs are set at a falling edge; one-shot strobes drop after the cycle
  task automatic tick(input string tag);
    #1;
    check_comb();
    @(posedge clk);
    model_edge();
    @(negedge clk);
    check_regs(tag);
    set_en = 0; rem_en = 0; wipe_all = 0; commit = 0;
  endtask

  task automatic do_set(input int l, input int s);
    set_en = 1; set_lvl = 6'(l); set_src = 7'(s);
  endtask
  task automatic do_rem(input int l, input int s);
    rem_en = 1; rem_lvl = 6'(l); rem_src = 7'(s);
  endtask

  initial begin
    #(200000 * 5);
    n_errs++; n_checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    rst = 1; set_en = 0; rem_en = 0; wipe_all = 0; commit = 0;
    set_lvl = 0; set_src = 0; rem_lvl = 0; rem_src = 0;
    sw_req = 0; cur_ipl = 0; pc_lo = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 0;
    model_reset();
    check_regs("R11 reset");

    // R1/R2: level stays marked until its last source leaves
    do_set(20, 5); tick("R1");
    do_set(20, 6); tick("R1");
    do_rem(20, 5); tick("R2 partial");
    do_rem(20, 6); tick("R2 empty");
    // R2: set and remove of the same bit in one cycle
    do_set(18, 9); do_rem(18, 9); tick("R2 same-bit");
    commit = 1; tick("R8 commit");
    // R3: wipe together with a set
    do_set(25, 1); wipe_all = 1; tick("R3 wipe");
    // R9: out-of-range commands
    do_set(40, 1); tick("R9 lvl");
    do_set(3, 64); tick("R9 src");
    do_rem(32, 0); tick("R9 rem");
    // R10: commit with nothing held
    commit = 1; tick("R10");
    // R5: software only with empty summary gives no request
    sw_req = 32'h0000_0080; tick("R5 no-summary");
    do_set(0, 2); tick("R5 lvl0");
    cur_ipl = 7; tick("R7 equal");
    cur_ipl = 6; tick("R7 greater");
    pc_lo = 2'b01; tick("R4 misaligned");
    pc_lo = 2'b10; tick("R4 misaligned");
    pc_lo = 2'b00;
    // R6: external beats software
    do_set(17, 3); tick("R6");
    commit = 1; tick("R8 commit+take");
    cur_ipl = 31; commit = 1; tick("R8 commit");
    commit = 1; tick("R10 again");
    sw_req = 32'h0001_0001; cur_ipl = 0; tick("R5 range");
    wipe_all = 1; sw_req = 0; tick("R3");

    // random traffic with a small source pool to force collisions
    for (int c = 0; c < 4000; c++) begin
      set_en = ($urandom % 2) == 0;
      set_lvl = ($urandom % 16 == 0) ? 6'($urandom % 64) : 6'(12 + $urandom % 8);
      set_src = ($urandom % 16 == 0) ? 7'($urandom % 128) : 7'($urandom % 4);
      rem_en = ($urandom % 3) != 0;
      rem_lvl = ($urandom % 16 == 0) ? 6'($urandom % 64) : 6'(12 + $urandom % 8);
      rem_src = ($urandom % 16 == 0) ? 7'($urandom % 128) : 7'($urandom % 4);
      wipe_all = ($urandom % 64) == 0;
      commit = ($urandom % 4) == 0;
      sw_req = ($urandom % 3 == 0) ? $urandom : 32'h0;
      cur_ipl = 6'($urandom % 34);
      pc_lo = ($urandom % 4 == 0) ? 2'($urandom) : 2'b00;
      tick("random");
    end

    $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
    $finish;
  end
endmodule